// File: doc/BRIEF.md
# Interrupt distributor register bank

This block keeps the per-line state of a small interrupt distributor: an enable bit, a pending bit, an 8-bit priority and a trigger-mode bit for each line. The line count is the parameter `NUM_IRQ` (default 64, a multiple of 32). Software reaches the state through a 32-bit register port qualified by a single valid strobe. Hardware interrupt inputs feed the pending state. A line set to edge mode latches a rising input. A line set to level mode reports pending for as long as its input is high.

Enable and pending state have no plain read/write register. Each is written through a pair of aliases, one that sets bits and one that clears them. Reading either alias returns the same current state. A combinational arbiter scans every line that is both enabled and pending. It presents the line with the smallest priority value, and a tie goes to the lowest line number. The result is presented only while at least one of the two group enable bits in the control register is set.

Top module: `intd_regbank`

## Requirements
- R1: After reset, all enable, pending, priority, trigger-mode and control state is zero and `irqValid` is low.
- R2: A write to word n of the set-enable alias (0x100 + 4n) enables line 32n+b for every 1 in bit b. Zero bits leave their lines unchanged. A read of word n at either 0x100 + 4n or 0x180 + 4n returns the enable bits of lines 32n..32n+31.
- R3: A write to word n of the clear-enable alias (0x180 + 4n) disables line 32n+b for every 1 in bit b. Zero bits leave their lines unchanged.
- R4: The pending aliases set (0x200 + 4n) and clear (0x280 + 4n) pending bits one-for-one, in the same bit layout as the enable aliases. A read of either alias returns the current pending bits.
- R5: The priority of line i is the byte at 0x400 + i. Word w (0x400 + 4w) holds line 4w+k in bits 8k+7:8k. It is written as a whole word and reads back unchanged.
- R6: Word w at 0xC00 + 4w selects the trigger mode of lines 16w..16w+15. Bit 2k+1 = 1 makes line 16w+k edge mode and 0 makes it level mode. Even bits are not stored and read as 0.
- R7: An edge-mode line sets its pending bit on the clock where its input is first seen high after being low. The bit then stays set until a clear-pending write. A rising edge in the same cycle as a clear of that line leaves the bit set.
- R8: A level-mode line reads as pending while its input is high. It drops when the input goes low, unless software has set its pending bit.
- R9: The read-only word at 0x004 returns NUM_IRQ/32 - 1 in bits 4:0 and zero elsewhere. Writes to it have no effect.
- R10: The control word at 0x000 stores group enables in bits 0 and 1, and its other bits read as 0. `irqValid` is high only while at least one of these bits is 1.
- R11: When valid, `irqId`/`irqPrio` give the enabled pending line with the smallest priority value, with ties going to the lowest line number. Both read 0 when `irqValid` is low.
- R12: A read (`regValid` high, `regWrite` low) returns its data on `rdData` with `rdValid` high one cycle later. Unmapped or misaligned addresses read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access strobe, one cycle per access |
| regWrite | input | 1 | 1 = write, 0 = read, qualified by regValid |
| regAddr | input | 16 | Byte address of the access |
| regWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, held until the next read |
| rdValid | output | 1 | High for one cycle when rdData carries a read result |
| irqIn | input | NUM_IRQ | Interrupt input lines |
| irqValid | output | 1 | A selected line is being presented |
| irqId | output | $clog2(NUM_IRQ) | Selected line number |
| irqPrio | output | 8 | Priority of the selected line |

## Verification
The assertions assume that `irqIn` is synchronous to `clk` and changes only between edges. They also assume one register access per cycle, with `regWrite` meaningful only while `regValid` is high. The bench drives every input on the falling edge, issues accesses one at a time through write and read tasks, and returns `regValid` low after each one. Edge-capture checks therefore see a clean low-to-high transition, and the set-wins case is produced by lining up an input rise and a clear write on the same rising edge.

// File: rtl/intd_pkg.sv
package intd_pkg;

  // Decoded write strobes handed from the control module to the datapath.
  typedef struct packed {
    logic        ctrlWr;
    logic        setEn;
    logic        clrEn;
    logic        setPend;
    logic        clrPend;
    logic        prioWr;
    logic        cfgWr;
    logic [7:0]  idx;
    logic [31:0] data;
  } strobe_t;

endpackage

// File: rtl/intd_arbiter.sv
module intd_arbiter #(
  parameter int NUM_IRQ = 64,
  localparam int ID_W = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]   cand,
  input  logic [NUM_IRQ*8-1:0] prioFlat,
  output logic                 found,
  output logic [ID_W-1:0]      bestId,
  output logic [7:0]           bestPrio
);

  // Linear scan from line 0 upward; strict compare keeps the lower id on ties.
  always_comb begin
    found    = 1'b0;
    bestId   = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!found || prioFlat[i*8 +: 8] < bestPrio)) begin
        found    = 1'b1;
        bestId   = ID_W'(i);
        bestPrio = prioFlat[i*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/intd_ctrl.sv
module intd_ctrl
  import intd_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [15:0]          regAddr,
  input  logic [31:0]          regWdata,
  input  logic [NUM_IRQ-1:0]   enableVec,
  input  logic [NUM_IRQ-1:0]   pendVec,
  input  logic [NUM_IRQ*8-1:0] prioFlat,
  input  logic [NUM_IRQ-1:0]   cfgEdge,
  input  logic [1:0]           ctrlEn,
  output strobe_t              strb,
  output logic [31:0]          rdData,
  output logic                 rdValid
);

  localparam int NUM_WORDS  = NUM_IRQ / 32;
  localparam int PRIO_WORDS = NUM_IRQ / 4;
  localparam int CFG_WORDS  = NUM_IRQ / 16;

  logic        aligned;
  logic [31:0] enIdx, prioIdx, cfgIdx;
  logic        hitCtrl, hitType, hitEnS, hitEnC, hitPdS, hitPdC, hitPrio, hitCfg;
  logic        wrStrobe, rdStrobe;
  logic [31:0] rdWord;

  always_comb begin
    aligned = (regAddr[1:0] == 2'b00);
    enIdx   = {27'b0, regAddr[6:2]};
    prioIdx = {24'b0, regAddr[9:2]};
    cfgIdx  = {26'b0, regAddr[7:2]};
    hitCtrl = aligned && (regAddr[15:2] == 14'd0);
    hitType = aligned && (regAddr[15:2] == 14'd1);
    hitEnS  = aligned && (regAddr[15:7] == 9'd2) && (enIdx < NUM_WORDS);
    hitEnC  = aligned && (regAddr[15:7] == 9'd3) && (enIdx < NUM_WORDS);
    hitPdS  = aligned && (regAddr[15:7] == 9'd4) && (enIdx < NUM_WORDS);
    hitPdC  = aligned && (regAddr[15:7] == 9'd5) && (enIdx < NUM_WORDS);
    hitPrio = aligned && (regAddr[15:10] == 6'd1) && (prioIdx < PRIO_WORDS);
    hitCfg  = aligned && (regAddr[15:8] == 8'h0C) && (cfgIdx < CFG_WORDS);
    wrStrobe = regValid && regWrite;
    rdStrobe = regValid && !regWrite;
  end

  // Write strobes toward the datapath
  always_comb begin
    strb.ctrlWr  = wrStrobe && hitCtrl;
    strb.setEn   = wrStrobe && hitEnS;
    strb.clrEn   = wrStrobe && hitEnC;
    strb.setPend = wrStrobe && hitPdS;
    strb.clrPend = wrStrobe && hitPdC;
    strb.prioWr  = wrStrobe && hitPrio;
    strb.cfgWr   = wrStrobe && hitCfg;
    strb.idx     = hitPrio ? regAddr[9:2] :
                   hitCfg  ? {2'b0, regAddr[7:2]} : {3'b0, regAddr[6:2]};
    strb.data    = regWdata;
  end

  // Read multiplexer
  always_comb begin
    rdWord = '0;
    if (hitCtrl) rdWord = {30'b0, ctrlEn};
    if (hitType) rdWord = {27'b0, 5'(NUM_WORDS - 1)};
    for (int w = 0; w < NUM_WORDS; w++) begin
      if ((hitEnS || hitEnC) && enIdx == w) rdWord = enableVec[w*32 +: 32];
      if ((hitPdS || hitPdC) && enIdx == w) rdWord = pendVec[w*32 +: 32];
    end
    for (int w = 0; w < PRIO_WORDS; w++) begin
      if (hitPrio && prioIdx == w) rdWord = prioFlat[w*32 +: 32];
    end
    for (int w = 0; w < CFG_WORDS; w++) begin
      if (hitCfg && cfgIdx == w) begin
        for (int k = 0; k < 16; k++) rdWord[2*k+1] = cfgEdge[w*16 + k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdStrobe;
      if (rdStrobe) rdData <= rdWord;
    end
  end

endmodule

// File: rtl/intd_datapath.sv
module intd_datapath
  import intd_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int ID_W = $clog2(NUM_IRQ)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [NUM_IRQ-1:0]   irqIn,
  output logic [NUM_IRQ-1:0]   enableVec,
  output logic [NUM_IRQ-1:0]   pendVec,
  output logic [NUM_IRQ*8-1:0] prioFlat,
  output logic [NUM_IRQ-1:0]   cfgEdge,
  output logic [1:0]           ctrlEn,
  output logic                 irqValid,
  output logic [ID_W-1:0]      irqId,
  output logic [7:0]           irqPrio
);

  localparam int NUM_WORDS  = NUM_IRQ / 32;
  localparam int PRIO_WORDS = NUM_IRQ / 4;
  localparam int CFG_WORDS  = NUM_IRQ / 16;

  logic [NUM_IRQ-1:0] pendLatch, irqPrev, riseVec;
  logic [NUM_IRQ-1:0] enSetM, enClrM, pdSetM, pdClrM;
  logic               found;
  logic [ID_W-1:0]    bestId;
  logic [7:0]         bestPrio;

  // Expand word-wide alias writes to full-width masks
  always_comb begin
    enSetM = '0;
    enClrM = '0;
    pdSetM = '0;
    pdClrM = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (strb.idx == 8'(w)) begin
        if (strb.setEn)   enSetM[w*32 +: 32] = strb.data;
        if (strb.clrEn)   enClrM[w*32 +: 32] = strb.data;
        if (strb.setPend) pdSetM[w*32 +: 32] = strb.data;
        if (strb.clrPend) pdClrM[w*32 +: 32] = strb.data;
      end
    end
  end

  assign riseVec = irqIn & ~irqPrev;
  // Level lines follow their input; edge lines show only the latch
  assign pendVec = pendLatch | (irqIn & ~cfgEdge);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableVec <= '0;
      pendLatch <= '0;
      irqPrev   <= '0;
    end else begin
      irqPrev   <= irqIn;
      enableVec <= (enableVec | enSetM) & ~enClrM;
      // Hardware edge capture is applied after the clear so it is never lost
      pendLatch <= (pendLatch & ~pdClrM) | pdSetM | (riseVec & cfgEdge);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prioFlat <= '0;
      cfgEdge  <= '0;
      ctrlEn   <= '0;
    end else begin
      if (strb.ctrlWr) ctrlEn <= strb.data[1:0];
      for (int w = 0; w < PRIO_WORDS; w++) begin
        if (strb.prioWr && strb.idx == 8'(w)) prioFlat[w*32 +: 32] <= strb.data;
      end
      for (int w = 0; w < CFG_WORDS; w++) begin
        if (strb.cfgWr && strb.idx == 8'(w)) begin
          for (int k = 0; k < 16; k++) cfgEdge[w*16 + k] <= strb.data[2*k+1];
        end
      end
    end
  end

  intd_arbiter #(.NUM_IRQ(NUM_IRQ)) uArb (
    .cand     (enableVec & pendVec),
    .prioFlat (prioFlat),
    .found    (found),
    .bestId   (bestId),
    .bestPrio (bestPrio)
  );

  always_comb begin
    irqValid = found && (ctrlEn != 2'b00);
    irqId    = irqValid ? bestId : '0;
    irqPrio  = irqValid ? bestPrio : '0;
  end

endmodule

// File: rtl/intd_regbank.sv
module intd_regbank
  import intd_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int ID_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [15:0]        regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        rdData,
  output logic               rdValid,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic               irqValid,
  output logic [ID_W-1:0]    irqId,
  output logic [7:0]         irqPrio
);

  strobe_t              strb;
  logic [NUM_IRQ-1:0]   enableVec, pendVec, cfgEdge;
  logic [NUM_IRQ*8-1:0] prioFlat;
  logic [1:0]           ctrlEn;

  intd_ctrl #(.NUM_IRQ(NUM_IRQ)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regValid  (regValid),
    .regWrite  (regWrite),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .enableVec (enableVec),
    .pendVec   (pendVec),
    .prioFlat  (prioFlat),
    .cfgEdge   (cfgEdge),
    .ctrlEn    (ctrlEn),
    .strb      (strb),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

  intd_datapath #(.NUM_IRQ(NUM_IRQ)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .irqIn     (irqIn),
    .enableVec (enableVec),
    .pendVec   (pendVec),
    .prioFlat  (prioFlat),
    .cfgEdge   (cfgEdge),
    .ctrlEn    (ctrlEn),
    .irqValid  (irqValid),
    .irqId     (irqId),
    .irqPrio   (irqPrio)
  );

endmodule

// File: rtl/intd_regbank_chk.sv
module intd_regbank_chk #(
  parameter int NUM_IRQ = 64,
  localparam int ID_W = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rstN,
  input logic               regValid,
  input logic               regWrite,
  input logic               rdValid,
  input logic [NUM_IRQ-1:0] irqIn,
  input logic               irqValid,
  input logic [ID_W-1:0]    irqId,
  input logic [NUM_IRQ-1:0] enableVec,
  input logic [NUM_IRQ-1:0] pendVec,
  input logic [NUM_IRQ-1:0] cfgEdge,
  input logic [1:0]         ctrlEn
);

  assert_group_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (ctrlEn != 2'b00));

  assert_pick_live_line_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (enableVec[irqId] && pendVec[irqId]));

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite) |=> rdValid);

  assert_no_spurious_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && !regWrite) |=> !rdValid);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : gLine
    assert_edge_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
      (cfgEdge[i] && $rose(irqIn[i])) |=> pendVec[i]);
    assert_level_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgEdge[i] && irqIn[i]) |-> pendVec[i]);
  end

endmodule

bind intd_regbank intd_regbank_chk #(.NUM_IRQ(NUM_IRQ)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regValid  (regValid),
  .regWrite  (regWrite),
  .rdValid   (rdValid),
  .irqIn     (irqIn),
  .irqValid  (irqValid),
  .irqId     (irqId),
  .enableVec (enableVec),
  .pendVec   (pendVec),
  .cfgEdge   (cfgEdge),
  .ctrlEn    (ctrlEn)
);

// File: tb/sim_intd_regbank.sv
`timescale 1ns/1ps
module sim_intd_regbank;

  localparam int NUM_IRQ = 64;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               regValid = 1'b0;
  logic               regWrite = 1'b0;
  logic [15:0]        regAddr = '0;
  logic [31:0]        regWdata = '0;
  logic [31:0]        rdData;
  logic               rdValid;
  logic [NUM_IRQ-1:0] irqIn = '0;
  logic               irqValid;
  logic [5:0]         irqId;
  logic [7:0]         irqPrio;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  intd_regbank #(.NUM_IRQ(NUM_IRQ)) u0 (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .rdData(rdData), .rdValid(rdValid),
    .irqIn(irqIn), .irqValid(irqValid), .irqId(irqId), .irqPrio(irqPrio)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    check("R12 rdValid", {31'b0, rdValid}, 32'd1);
    d = rdData;
  endtask

  task automatic rdCheck(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic outCheck(input string req, input logic v, input logic [5:0] id, input logic [7:0] p);
    check({req, " irqValid"}, {31'b0, irqValid}, {31'b0, v});
    check({req, " irqId"}, {26'b0, irqId}, {26'b0, id});
    check({req, " irqPrio"}, {24'b0, irqPrio}, {24'b0, p});
  endtask

  task automatic testReset();
    outCheck("R1 reset", 1'b0, 6'd0, 8'd0);
    rdCheck("R1 ctrl reset", 16'h000, 32'h0);
    rdCheck("R1 enable reset", 16'h104, 32'h0);
    rdCheck("R1 pending reset", 16'h200, 32'h0);
    rdCheck("R1 prio reset", 16'h43C, 32'h0);
    rdCheck("R1 cfg reset", 16'hC00, 32'h0);
  endtask

  task automatic testType();
    rdCheck("R9 type", 16'h004, 32'h1);
    wr(16'h004, 32'hFFFF_FFFF);
    rdCheck("R9 type after write", 16'h004, 32'h1);
  endtask

  task automatic testCtrl();
    wr(16'h000, 32'hFFFF_FFFF);
    rdCheck("R10 ctrl bits", 16'h000, 32'h3);
  endtask

  task automatic testEnable();
    wr(16'h104, 32'h0000_0005);
    rdCheck("R2 set-enable readback", 16'h104, 32'h5);
    rdCheck("R2 read via clear alias", 16'h184, 32'h5);
    wr(16'h104, 32'h0);
    rdCheck("R2 zero bits no effect", 16'h104, 32'h5);
    wr(16'h184, 32'h0000_0001);
    rdCheck("R3 clear-enable", 16'h104, 32'h4);
    wr(16'h184, 32'h0);
    rdCheck("R3 zero bits no effect", 16'h184, 32'h4);
    rdCheck("R2 other word untouched", 16'h100, 32'h0);
  endtask

  task automatic testPending();
    wr(16'h200, 32'h8000_0000);
    rdCheck("R4 set-pending", 16'h280, 32'h8000_0000);
    wr(16'h280, 32'h8000_0000);
    rdCheck("R4 clear-pending", 16'h200, 32'h0);
  endtask

  task automatic testPrio();
    wr(16'h400, 32'h4433_2211);
    rdCheck("R5 prio readback", 16'h400, 32'h4433_2211);
    wr(16'h400, 32'h0);
    rdCheck("R12 unmapped prio word", 16'h440, 32'h0);
    rdCheck("R12 misaligned read", 16'h401, 32'h0);
    wr(16'h105, 32'hFFFF_FFFF);
    rdCheck("R12 misaligned write ignored", 16'h104, 32'h4);
  endtask

  task automatic testCfg();
    wr(16'hC00, 32'hFFFF_FFFF);
    rdCheck("R6 cfg odd bits only", 16'hC00, 32'hAAAA_AAAA);
    rdCheck("R6 other cfg word", 16'hC08, 32'h0);
  endtask

  task automatic testEdge();
    @(negedge clk); irqIn[3] = 1'b1;
    rdCheck("R7 edge latched", 16'h200, 32'h8);
    @(negedge clk); irqIn[3] = 1'b0;
    rdCheck("R7 edge held after input low", 16'h200, 32'h8);
    wr(16'h280, 32'h8);
    rdCheck("R7 edge cleared", 16'h200, 32'h0);
    // set by software, then rise coincident with clear
    wr(16'h200, 32'h20);
    @(negedge clk);
    irqIn[5] = 1'b1;
    regValid = 1'b1; regWrite = 1'b1; regAddr = 16'h280; regWdata = 32'h20;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    irqIn[5] = 1'b0;
    rdCheck("R7 rise beats clear", 16'h200, 32'h20);
  endtask

  task automatic testLevel();
    @(negedge clk); irqIn[40] = 1'b1;
    rdCheck("R8 level high pending", 16'h204, 32'h100);
    @(negedge clk); irqIn[40] = 1'b0;
    rdCheck("R8 level low not pending", 16'h284, 32'h0);
  endtask

  task automatic testArb();
    wr(16'h428, 32'h0000_3040);
    wr(16'h204, 32'h0000_0300);
    wr(16'h104, 32'h0000_0300);
    outCheck("R11 lowest value wins", 1'b1, 6'd41, 8'h30);
    wr(16'h100, 32'h20);
    outCheck("R11 zero priority line", 1'b1, 6'd5, 8'h00);
    wr(16'h280, 32'h20);
    outCheck("R11 back after clear", 1'b1, 6'd41, 8'h30);
    wr(16'h428, 32'h0000_3030);
    outCheck("R11 tie to lower id", 1'b1, 6'd40, 8'h30);
    wr(16'h000, 32'h0);
    outCheck("R10 no group enabled", 1'b0, 6'd0, 8'h00);
    wr(16'h000, 32'h2);
    outCheck("R10 group1 alone", 1'b1, 6'd40, 8'h30);
    wr(16'h000, 32'h1);
    outCheck("R10 group0 alone", 1'b1, 6'd40, 8'h30);
    wr(16'h184, 32'h0000_0300);
    outCheck("R11 nothing enabled", 1'b0, 6'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testType();
    testCtrl();
    testEnable();
    testPending();
    testPrio();
    testCfg();
    testEdge();
    testLevel();
    testArb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule